// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by reading a radix translation tree from memory. A request carries the effective address, a store flag, an instruction-fetch flag, a privilege flag and a translation-enable flag, plus the current process-table register and process identifier. With translation off the address comes back unchanged after one cycle. With translation on, the walker first reads the process's table entry. That entry gives the tree size, the root directory size and the root base. The walker then checks the address against the tree's segment and descends one directory level per memory read until it reaches a leaf or a fault.

The number of levels is not fixed. Each level's index width comes from a 5-bit size field in the entry above it, and the remaining shift drops by that width at every step. A separate checker judges the leaf's access bits and its referenced/changed bits. The walk ends with a single-cycle `done` pulse that carries either the real address or a fault code. Memory is reached through one outstanding 8-byte read on a level-sensitive request/response port. Table entries are used as read, with no byte reordering.

Top module: `radix_walker`

## Requirements
- R1: With `req_xlate` low, a request accepted in idle produces `done` on the next cycle with `done_addr` equal to `req_ea`, `done_fault` 0, and no memory read.
- R2: The first read of a translated walk goes to {8'h00, tbl[55:36], (tbl[35:12] & ~m) | (id[31:8] & m), id[7:0], 4'h0}. Here m has tbl[4:0] low-order ones, and id is zero when EA bit 63 is set and `proc_id` otherwise.
- R3: The process entry gives tree size {d[62:61], d[7:5]}, root size d[4:0] and base {d[55:8], 8'h00}. If EA[63] differs from EA[62], or if any bit of EA[61:31] at or above the tree-size position is set, the walk ends with fault code 3 and makes no further read.
- R4: A size field below 5, above 16, or above the remaining shift ends the walk with fault code 2 and makes no further read. At the root the remaining shift is tree size + 19. Otherwise the remaining shift is reduced by the size field.
- R5: An entry with bit 63 (valid) clear ends the walk with fault code 1.
- R6: Each directory read goes to {8'h00, base[55:19], (base[18:3] & ~k) | (x & k), 3'b000}. Here k has size-field low-order ones and x is the low 16 bits of EA[61:12] shifted right by the remaining shift. A valid entry with bit 62 (leaf) clear supplies the next base {d[55:8], 8'h00} and the next size d[4:0].
- R7: A leaf that passes its checks yields `done_addr` = {8'h00, (pte[55:12] & ~f) | (EA[55:12] & f), EA[11:0]} with fault code 0. Here f has the remaining shift as its count of low-order ones.
- R8: Access is refused with fault code 4 in two cases. The first is an unprivileged request to a leaf with bit 3 set. The second is a request that lacks its right: a fetch needs bit 0 set and bit 5 clear, a load needs bit 1 or bit 2, and a store needs bit 1. This refusal takes precedence over R9.
- R9: A leaf that passes R8 ends with fault code 5 when bit 8 (referenced) is clear, or when the request is a store and bit 7 (changed) is clear. On any fault `done_addr` is zero.
- R10: `mem_req_valid` and `mem_req_addr` hold steady until `mem_rsp_valid` completes the read, and at most one read is outstanding.
- R11: `done` is high for exactly one cycle per accepted request. `req_valid` is ignored while a walk is in progress, and `done`, `mem_req_valid` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_ea | input | 64 | Effective address |
| req_is_store | input | 1 | Access is a store |
| req_is_fetch | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Access is privileged |
| req_xlate | input | 1 | Translation enabled |
| proc_tbl_reg | input | 64 | Process-table base and size register |
| proc_id | input | 32 | Current process identifier |
| mem_req_valid | output | 1 | Read request, held until response |
| mem_req_addr | output | 64 | Address of the 8-byte entry to read |
| mem_rsp_valid | input | 1 | Read data valid; completes the request |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | One-cycle completion pulse |
| done_addr | output | 64 | Real address (zero on fault) |
| done_fault | output | 3 | 0 ok, 1 invalid, 2 bad tree, 3 segment, 4 permission, 5 RC |

## Verification
Two things can meet in one cycle: a new `req_valid` pulse and an ongoing walk. During every translated walk the bench drives a stray untranslated request with a different address. It is judged by whether a `done` appears carrying that address, or whether the walk's own result changes. A second collision is a response that completes one directory read in the same cycle the next read's address is formed. Chained directory levels provoke it, and the bench matches each read address to the reference model's expected sequence. It also confirms that nothing remains of that sequence when `done` fires, which catches reads made after an early abort.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned ENTRY_W  = 64;
    localparam int unsigned BASE_W   = 56;
    localparam int unsigned PID_W    = 32;
    localparam int unsigned SIZE_W   = 5;
    localparam int unsigned SHIFT_W  = SIZE_W + 1;
    localparam int unsigned SEG_BIAS = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROC_RD,
        ST_SEG_CHK,
        ST_LVL_RD,
        ST_LEAF_CHK,
        ST_DONE
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_BADTREE = 3'd2,
        FLT_SEGMENT = 3'd3,
        FLT_PERM    = 3'd4,
        FLT_RC      = 3'd5
    } walk_fault_e;

    typedef struct packed {
        logic [SIZE_W-1:0] tree_sz;
        logic [SIZE_W-1:0] root_sz;
        logic [BASE_W-1:0] base;
    } proc_ent_t;

    // n low-order ones, n up to 63
    function automatic logic [63:0] low_ones(input logic [5:0] n);
        logic [64:0] t;
        t = (65'd1 << n) - 65'd1;
        return t[63:0];
    endfunction

    function automatic proc_ent_t decode_proc(input logic [ENTRY_W-1:0] d);
        proc_ent_t p;
        p.tree_sz = {d[62:61], d[7:5]};
        p.root_sz = d[4:0];
        p.base    = {d[55:8], 8'h00};
        return p;
    endfunction

endpackage

// File: rtl/radix_addr_gen.sv
module radix_addr_gen
    import radix_walk_pkg::*;
(
    input  logic [ADDR_W-1:0]  ea,
    input  logic [ENTRY_W-1:0] tbl_reg,
    input  logic [PID_W-1:0]   pid,
    input  logic [BASE_W-1:0]  base,
    input  logic [SIZE_W-1:0]  lvl_bits,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ENTRY_W-1:0] pte,
    output logic [ADDR_W-1:0]  proc_addr,
    output logic [ADDR_W-1:0]  level_addr,
    output logic [ADDR_W-1:0]  real_addr
);
    logic [PID_W-1:0] effpid;
    logic [63:0]      ones_pt, ones_lv, ones_fm;
    logic [23:0]      m24;
    logic [15:0]      m16;
    logic [49:0]      va_sh;
    logic [15:0]      idx;
    logic [43:0]      fm;

    always_comb begin
        effpid  = ea[63] ? '0 : pid;
        ones_pt = low_ones({1'b0, tbl_reg[4:0]});
        m24     = ones_pt[23:0];
        proc_addr = {8'h00, tbl_reg[55:36],
                     (tbl_reg[35:12] & ~m24) | (effpid[31:8] & m24),
                     effpid[7:0], 4'h0};

        ones_lv = low_ones({1'b0, lvl_bits});
        m16     = ones_lv[15:0];
        va_sh   = ea[61:12] >> shift;
        idx     = va_sh[15:0];
        level_addr = {8'h00, base[55:19], (base[18:3] & ~m16) | (idx & m16), 3'b000};

        ones_fm = low_ones(shift);
        fm      = ones_fm[43:0];
        real_addr = {8'h00, (pte[55:12] & ~fm) | (ea[55:12] & fm), ea[11:0]};
    end

    logic unused_bits;
    assign unused_bits = ^{ea[62], tbl_reg[63:56], tbl_reg[11:5], base[2:0],
                           pte[63:56], pte[11:0], ones_pt[63:24], ones_lv[63:16],
                           ones_fm[63:44], va_sh[49:16]};
endmodule

// File: rtl/radix_perm_chk.sv
module radix_perm_chk
    import radix_walk_pkg::*;
(
    input  logic [ENTRY_W-1:0] pte,
    input  logic               priv,
    input  logic               store,
    input  logic               fetch,
    output walk_fault_e        verdict
);
    logic perm_ok, rc_ok;

    always_comb begin
        perm_ok = 1'b0;
        if (priv || !pte[3]) begin
            if (fetch) perm_ok = pte[0] & ~pte[5];
            else       perm_ok = pte[1] | (pte[2] & ~store);
        end
        rc_ok = pte[8] & (pte[7] | ~store);
        if (!perm_ok)    verdict = FLT_PERM;
        else if (!rc_ok) verdict = FLT_RC;
        else             verdict = FLT_NONE;
    end

    logic unused_bits;
    assign unused_bits = ^{pte[63:9], pte[6], pte[4]};
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int unsigned MIN_LEVEL_BITS = 5,
    parameter int unsigned MAX_LEVEL_BITS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_ea,
    input  logic               req_is_store,
    input  logic               req_is_fetch,
    input  logic               req_priv,
    input  logic               req_xlate,
    input  logic [ENTRY_W-1:0] proc_tbl_reg,
    input  logic [PID_W-1:0]   proc_id,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done,
    output logic [ADDR_W-1:0]  done_addr,
    output logic [2:0]         done_fault
);
    localparam logic [SHIFT_W-1:0] MIN_SZ = SHIFT_W'(MIN_LEVEL_BITS);
    localparam logic [SHIFT_W-1:0] MAX_SZ = SHIFT_W'(MAX_LEVEL_BITS);
    localparam logic [SHIFT_W-1:0] BIAS   = SHIFT_W'(SEG_BIAS);

    walk_state_e        state;
    walk_fault_e        fault_q;
    logic [ADDR_W-1:0]  ea_q, res_addr_q;
    logic               store_q, fetch_q, priv_q;
    logic [ENTRY_W-1:0] tbl_q, pte_q;
    logic [PID_W-1:0]   pid_q;
    logic [SIZE_W-1:0]  rts_q, lvl_bits_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [BASE_W-1:0]  base_q;

    logic [ADDR_W-1:0]  proc_addr, level_addr, real_addr;
    walk_fault_e        verdict;
    proc_ent_t          pe;
    logic [SIZE_W-1:0]  nls;
    logic [SHIFT_W-1:0] limit;
    logic [63:0]        seg_ones;
    logic               seg_fail, root_bad, lvl_bad;

    radix_addr_gen u_addr (
        .ea(ea_q), .tbl_reg(tbl_q), .pid(pid_q), .base(base_q),
        .lvl_bits(lvl_bits_q), .shift(shift_q), .pte(pte_q),
        .proc_addr(proc_addr), .level_addr(level_addr), .real_addr(real_addr)
    );

    radix_perm_chk u_perm (
        .pte(pte_q), .priv(priv_q), .store(store_q), .fetch(fetch_q),
        .verdict(verdict)
    );

    always_comb begin
        pe       = decode_proc(mem_rsp_data);
        nls      = mem_rsp_data[4:0];
        lvl_bad  = ({1'b0, nls} < MIN_SZ) || ({1'b0, nls} > MAX_SZ) ||
                   ({1'b0, nls} > shift_q);
        limit    = {1'b0, rts_q} + BIAS;
        seg_ones = low_ones({1'b0, rts_q});
        seg_fail = (ea_q[63] ^ ea_q[62]) | (|(ea_q[61:31] & ~seg_ones[30:0]));
        root_bad = ({1'b0, lvl_bits_q} < MIN_SZ) || ({1'b0, lvl_bits_q} > MAX_SZ) ||
                   ({1'b0, lvl_bits_q} > limit);
    end

    assign mem_req_valid = (state == ST_PROC_RD) || (state == ST_LVL_RD);
    assign mem_req_addr  = (state == ST_PROC_RD) ? proc_addr : level_addr;
    assign done          = (state == ST_DONE);
    assign done_addr     = res_addr_q;
    assign done_fault    = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fault_q    <= FLT_NONE;
            res_addr_q <= '0;
            ea_q       <= '0;
            store_q    <= 1'b0;
            fetch_q    <= 1'b0;
            priv_q     <= 1'b0;
            tbl_q      <= '0;
            pid_q      <= '0;
            pte_q      <= '0;
            rts_q      <= '0;
            lvl_bits_q <= '0;
            shift_q    <= '0;
            base_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    ea_q    <= req_ea;
                    store_q <= req_is_store;
                    fetch_q <= req_is_fetch;
                    priv_q  <= req_priv;
                    tbl_q   <= proc_tbl_reg;
                    pid_q   <= proc_id;
                    if (!req_xlate) begin
                        res_addr_q <= req_ea;
                        fault_q    <= FLT_NONE;
                        state      <= ST_DONE;
                    end else begin
                        state <= ST_PROC_RD;
                    end
                end
                ST_PROC_RD: if (mem_rsp_valid) begin
                    rts_q      <= pe.tree_sz;
                    lvl_bits_q <= pe.root_sz;
                    base_q     <= pe.base;
                    state      <= ST_SEG_CHK;
                end
                ST_SEG_CHK: begin
                    if (seg_fail) begin
                        fault_q    <= FLT_SEGMENT;
                        res_addr_q <= '0;
                        state      <= ST_DONE;
                    end else if (root_bad) begin
                        fault_q    <= FLT_BADTREE;
                        res_addr_q <= '0;
                        state      <= ST_DONE;
                    end else begin
                        shift_q <= limit - {1'b0, lvl_bits_q};
                        state   <= ST_LVL_RD;
                    end
                end
                ST_LVL_RD: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[63]) begin
                        fault_q    <= FLT_INVALID;
                        res_addr_q <= '0;
                        state      <= ST_DONE;
                    end else if (mem_rsp_data[62]) begin
                        pte_q <= mem_rsp_data;
                        state <= ST_LEAF_CHK;
                    end else if (lvl_bad) begin
                        fault_q    <= FLT_BADTREE;
                        res_addr_q <= '0;
                        state      <= ST_DONE;
                    end else begin
                        base_q     <= {mem_rsp_data[55:8], 8'h00};
                        lvl_bits_q <= nls;
                        shift_q    <= shift_q - {1'b0, nls};
                    end
                end
                ST_LEAF_CHK: begin
                    fault_q    <= verdict;
                    res_addr_q <= (verdict == FLT_NONE) ? real_addr : '0;
                    state      <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_quiet_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req_valid);

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && !req_xlate) |=>
            (done && done_addr == $past(req_ea) && done_fault == 3'd0));

    p_seg_no_read_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEG_CHK && seg_fail) |=> (done && !mem_req_valid && done_fault == 3'd3));

    p_leaf_verdict_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEAF_CHK) |=>
            (done && (done_fault == 3'd0 || done_fault == 3'd4 || done_fault == 3'd5)));
endmodule

// File: tb/test_radix_walker.sv
`timescale 1ns/1ps
module test_radix_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic        req_is_store = 1'b0, req_is_fetch = 1'b0, req_priv = 1'b0, req_xlate = 1'b0;
    logic [63:0] proc_tbl_reg = '0;
    logic [31:0] proc_id = '0;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [63:0] done_addr;
    logic [2:0]  done_fault;

    radix_walker i_radix_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
        .req_is_store(req_is_store), .req_is_fetch(req_is_fetch),
        .req_priv(req_priv), .req_xlate(req_xlate),
        .proc_tbl_reg(proc_tbl_reg), .proc_id(proc_id),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_addr(done_addr), .done_fault(done_fault)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_cmp = 0, n_bad = 0, cyc = 0;
    localparam int LAT = 2;
    logic [63:0] pmem [logic [63:0]];
    logic [63:0] exp_q [$];
    logic [63:0] exp_addr;
    int          exp_flt;
    bit          pending = 0;
    string       cur_tag = "reset";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        exp_q.push_back(a);
        return pmem.exists(a) ? pmem[a] : 64'd0;
    endfunction

    // behavioural reference walk
    task automatic ref_walk(input logic [63:0] ea, input bit st, input bit fe, input bit pr,
                            input bit vi, input logic [31:0] id, input logic [63:0] ptb);
        logic [31:0] eid;
        logic [63:0] a, e, base, v, ix, ra;
        int ps, rts, rem, sz, nls;
        bit perm, rc;
        exp_q.delete();
        exp_addr = 64'd0;
        if (!vi) begin exp_addr = ea; exp_flt = 0; return; end
        eid = ea[63] ? 32'd0 : id;
        ps  = int'(ptb[4:0]);
        a = 64'd0;
        a[55:36] = ptb[55:36];
        for (int i = 0; i < 24; i++) a[12+i] = (i < ps) ? eid[8+i] : ptb[12+i];
        a[11:4] = eid[7:0];
        e = rd(a);
        rts = int'({e[62:61], e[7:5]});
        sz  = int'(e[4:0]);
        base = {8'h00, e[55:8], 8'h00};
        if (ea[63] != ea[62]) begin exp_flt = 3; return; end
        for (int i = 31; i <= 61; i++)
            if ((i - 31) >= rts && ea[i]) begin exp_flt = 3; return; end
        rem = rts + 19;
        if (sz < 5 || sz > 16 || sz > rem) begin exp_flt = 2; return; end
        rem = rem - sz;
        for (int lvl = 0; lvl < 12; lvl++) begin
            v  = {2'b00, ea[61:0]} >> (12 + rem);
            ix = v & ((64'd1 << sz) - 64'd1);
            a  = (base & ~(((64'd1 << sz) - 64'd1) << 3)) | (ix << 3);
            e  = rd(a);
            if (!e[63]) begin exp_flt = 1; return; end
            if (e[62]) begin
                perm = 0;
                if (pr || !e[3]) perm = fe ? (e[0] && !e[5]) : (e[1] || (e[2] && !st));
                rc = e[8] && (e[7] || !st);
                if (!perm) begin exp_flt = 4; return; end
                if (!rc)   begin exp_flt = 5; return; end
                ra = 64'd0;
                for (int i = 12; i <= 55; i++) ra[i] = ((i - 12) < rem) ? ea[i] : e[i];
                ra[11:0] = ea[11:0];
                exp_addr = ra; exp_flt = 0; return;
            end
            nls = int'(e[4:0]);
            if (nls < 5 || nls > 16 || nls > rem) begin exp_flt = 2; return; end
            rem  = rem - nls;
            sz   = nls;
            base = {8'h00, e[55:8], 8'h00};
        end
        exp_flt = 2;
    endtask

    // memory responder: checks R6 read sequence and R10 hold
    int lat_cnt = 0;
    logic [63:0] first_addr;
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            lat_cnt = 0;
        end else if (mem_req_valid) begin
            if (lat_cnt == 0) first_addr = mem_req_addr;
            if (lat_cnt == LAT) begin
                chk(mem_req_addr == first_addr, {cur_tag, " R10 request held"}, mem_req_addr, first_addr);
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " R6 unexpected read"}, mem_req_addr, 64'd0);
                end else begin
                    chk(mem_req_addr == exp_q[0], {cur_tag, " R6 read address"}, mem_req_addr, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                mem_rsp_data  = pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'd0;
                mem_rsp_valid = 1'b1;
            end else begin
                lat_cnt++;
            end
        end
    end

    // per-clock comparison of outputs
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (pending) begin
                    chk(done_fault == 3'(exp_flt), {cur_tag, " fault code"}, 64'(done_fault), 64'(exp_flt));
                    chk(done_addr == exp_addr, {cur_tag, " result address"}, done_addr, exp_addr);
                    pending = 0;
                end else begin
                    chk(1'b0, {cur_tag, " R11 done without request"}, 64'(done), 64'd0);
                end
            end else if (!pending) begin
                chk(!mem_req_valid, {cur_tag, " R11 idle has no read"}, 64'(mem_req_valid), 64'd0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            chk(1'b0, "watchdog expired", 64'(cyc), 64'd50000);
            summary();
            $finish;
        end
    end

    task automatic run(input string tag, input logic [63:0] ea, input bit st, input bit fe,
                       input bit pr, input bit vi, input logic [31:0] id, input logic [63:0] ptb);
        ref_walk(ea, st, fe, pr, vi, id, ptb);
        cur_tag = tag;
        @(negedge clk);
        req_ea = ea; req_is_store = st; req_is_fetch = fe; req_priv = pr;
        req_xlate = vi; proc_id = id; proc_tbl_reg = ptb; req_valid = 1'b1;
        pending = 1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!vi) chk(done === 1'b1, {tag, " R1 one-cycle latency"}, 64'(done), 64'd1);
        else begin
            // R11: stray request during a walk must be ignored
            @(negedge clk);
            req_valid = 1'b1; req_ea = ~ea; req_xlate = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (pending) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " R3/R4 reads left unissued"}, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
    endtask

    localparam logic [63:0] PTB  = 64'h0000_0000_0100_0000;
    localparam logic [63:0] PTB1 = 64'h0000_0000_0100_0001;

    initial begin
        pmem[64'h0100_0000] = 64'h4000_0000_0003_00AD; // id 0: tree 21, root 13
        pmem[64'h0100_0010] = 64'h4000_0000_0003_00A4; // id 1: root size 4
        pmem[64'h0100_0020] = 64'h4000_0000_0003_00B1; // id 2: root size 17
        pmem[64'h0100_0030] = 64'h0000_0000_0010_0010; // id 3: tree 0, root 16
        pmem[64'h0100_1000] = 64'h4000_0000_0003_00AD; // wide-id slot
        pmem[64'h0003_0000] = 64'h8000_0000_0004_0009; // directory, next size 9
        pmem[64'h0004_0000] = 64'hC000_0001_0000_0187; // leaf rwx, R C
        pmem[64'h0004_0008] = 64'hC000_0002_0000_0106; // leaf rw, R, no C
        pmem[64'h0004_0018] = 64'hC000_0003_0000_010A; // leaf priv-only, read, R
        pmem[64'h0010_0000] = 64'h8000_0000_0020_0005; // size 5 > remaining 3

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11 reset done low", 64'(done), 64'd0);
        chk(mem_req_valid == 1'b0, "R11 reset no read", 64'(mem_req_valid), 64'd0);

        run("R1 bypass",             64'hDEAD_BEEF_0000_1234, 0, 0, 1, 0, 32'd0, PTB);
        run("R7 load walk",          64'h0000_0000_1234_5678, 0, 0, 1, 1, 32'd0, PTB);
        run("R8 fetch allowed",      64'h0000_0000_1234_5678, 0, 1, 0, 1, 32'd0, PTB);
        run("R7 second leaf",        64'h0000_0000_4000_0ABC, 0, 0, 1, 1, 32'd0, PTB);
        run("R9 store without C",    64'h0000_0000_4000_0ABC, 1, 0, 1, 1, 32'd0, PTB);
        run("R8 fetch no exec",      64'h0000_0000_4000_0ABC, 0, 1, 1, 1, 32'd0, PTB);
        run("R8 unpriv on priv",     64'h0000_0000_C000_1000, 0, 0, 0, 1, 32'd0, PTB);
        run("R9 priv store RC",      64'h0000_0000_C000_1000, 1, 0, 1, 1, 32'd0, PTB);
        run("R8 perm over RC",       64'h0000_0000_C000_1000, 1, 0, 0, 1, 32'd0, PTB);
        run("R7 priv load",          64'h0000_0000_C000_1000, 0, 0, 1, 1, 32'd0, PTB);
        run("R5 invalid leaf",       64'h0000_0000_8000_0000, 0, 0, 1, 1, 32'd0, PTB);
        run("R6 root index high",    64'h0008_0000_0000_0000, 0, 0, 1, 1, 32'd0, PTB);
        run("R3 top bits differ",    64'h8000_0000_0000_0000, 0, 0, 1, 1, 32'd0, PTB);
        run("R3 above tree size",    64'h0010_0000_0000_0000, 0, 0, 1, 1, 32'd0, PTB);
        run("R2 id forced zero",     64'hC000_0000_0000_0000, 0, 0, 1, 1, 32'd1, PTB);
        run("R4 root too small",     64'h0000_0000_0000_1000, 0, 0, 1, 1, 32'd1, PTB);
        run("R4 root too large",     64'h0000_0000_0000_1000, 0, 0, 1, 1, 32'd2, PTB);
        run("R4 level over shift",   64'h0000_0000_0000_0000, 0, 0, 1, 1, 32'd3, PTB);
        run("R3 small tree segment", 64'h0000_0000_8000_0000, 0, 0, 1, 1, 32'd3, PTB);
        run("R2 wide id mask",       64'h0000_0000_1234_5678, 0, 0, 1, 1, 32'h100, PTB1);
        run("R1 bypass again",       64'h0123_4567_89AB_CDEF, 1, 0, 0, 0, 32'd3, PTB);

        summary();
        $finish;
    end
endmodule